// File: doc/BRIEF.md
# Banked Window Memory Expansion Registers

This block holds the registers and the address translation for a banked RAM expansion on an 8-bit home-computer bus. The CPU sees a fixed 256-byte window in the page at $DE00–$DEFF. Two write-only registers in the page at $DFxx choose which 256-byte page of a linear expansion memory shows up in that window. A 16KB block number is written at $DFFF. A page number within that block, from 0 to 63, is written at $DFFE.

Each window access gives a downstream memory controller three things: a physical address, a window-select strobe and a write direction. The physical address is the concatenation of block, page and the low CPU address byte. The default block register is 6 bits wide, which gives 1MB and a 20-bit address. A parameter widens the block register to 8 bits, which gives 4MB and a 22-bit address. The registers cannot be read back, and the block does not drive the data bus.

Top module: `bankwin_regs`

## Requirements
- R1: After reset the block and page registers are both 0, so mem_addr equals {zeros, cpu_addr[7:0]}.
- R2: A clock edge with io2_sel=1, cpu_wr=1 and cpu_addr=16'hDFFF loads the block register from cpu_data. The new value shows in mem_addr from the next cycle.
- R3: A clock edge with io2_sel=1, cpu_wr=1 and cpu_addr=16'hDFFE loads cpu_data[5:0] into the 6-bit page register. Bits 7:6 are ignored.
- R4: mem_addr = {block, page, cpu_addr[7:0]}. The page occupies bits [13:8] and the block occupies the bits above it.
- R5: mem_sel is 1 exactly when io1_sel=1 and cpu_addr[15:8]=8'hDE.
- R6: mem_we is 1 exactly when mem_sel=1 and cpu_wr=1.
- R7: The registers do not change on a read (cpu_wr=0), on a write with io2_sel=0, or on a write to any $DFxx address other than $DFFE/$DFFF.
- R8: With the default 6-bit block register, bits 7:6 of a block write are ignored.
- R9: With WIDE_BLOCK=1 the block register takes all 8 data bits, and mem_addr is 22 bits wide with the block at [21:14].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-qualifying clock; register writes are taken on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_wr | input | 1 | 1 = CPU write cycle, 0 = read |
| io1_sel | input | 1 | I/O-1 area select, active high |
| io2_sel | input | 1 | I/O-2 area select, active high |
| mem_addr | output | 20 (22 wide) | Physical expansion-memory address |
| mem_sel | output | 1 | Window access strobe to the memory controller |
| mem_we | output | 1 | Write direction for the window access |

## Verification
A vector table walks window reads and writes at the low, middle and high offsets of the window. Between them it writes the block and page registers with values whose unused upper bits are set. Each row therefore shows whether the page field lands in [13:8], whether the block lands above it, and whether the top data bits are dropped. Near-miss stimuli are also in the table: a read of $DFFF, a write without io2_sel, a write to $DFFD and an io1_sel access outside $DExx. These separate a correct decode from one that ignores direction, select or low address bits. Directed tests cover reset in the middle of a run, and a second, wide-block instance that must keep all eight block bits.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

  localparam int PAGE_W = 6;
  localparam int OFS_W  = 8;
  localparam int CPU_AW = 16;

  // High byte of the CPU address selects the 256-byte bus page
  function automatic logic page_hit(input logic [CPU_AW-1:0] a, input logic [7:0] hi);
    return a[CPU_AW-1:OFS_W] == hi;
  endfunction

  // Register decode: full address match
  function automatic logic reg_hit(input logic [CPU_AW-1:0] a, input logic [7:0] hi,
                                   input logic [7:0] lo);
    return (a[CPU_AW-1:OFS_W] == hi) && (a[OFS_W-1:0] == lo);
  endfunction

  // Width of the physical address for a given block width
  function automatic int phys_width(input int blk_w);
    return blk_w + PAGE_W + OFS_W;
  endfunction

endpackage

// File: rtl/bankwin_decode.sv
module bankwin_decode
  import bankwin_pkg::*;
#(
  parameter logic [7:0] WIN_PAGE = 8'hDE,
  parameter logic [7:0] REG_PAGE = 8'hDF,
  parameter logic [7:0] BLK_OFS  = 8'hFF,
  parameter logic [7:0] PG_OFS   = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              io1_sel,
  input  logic              io2_sel,
  output logic              win_hit,
  output logic              win_we,
  output logic              blk_wr,
  output logic              pg_wr
);

  logic reg_wr_cycle;

  assign reg_wr_cycle = io2_sel && cpu_wr;
  assign blk_wr  = reg_wr_cycle && reg_hit(cpu_addr, REG_PAGE, BLK_OFS);
  assign pg_wr   = reg_wr_cycle && reg_hit(cpu_addr, REG_PAGE, PG_OFS);
  assign win_hit = io1_sel && page_hit(cpu_addr, WIN_PAGE);
  assign win_we  = win_hit && cpu_wr;

  // R7: at most one register is written per cycle, and never on a read
  p_one_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_wr && pg_wr));
  p_no_read_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |-> !(blk_wr || pg_wr));
  // R6: write direction only inside the window
  p_we_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_we |-> win_hit);

endmodule

// File: rtl/bankwin_reg.sv
module bankwin_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R2/R3: a load takes the value presented at the edge
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));
  // R7: without a load the register holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  // R1: leaving reset the register is clear
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == '0);

endmodule

// File: rtl/bankwin_compose.sv
module bankwin_compose
  import bankwin_pkg::*;
#(
  parameter int BLK_W = 6,
  localparam int PHYS_W = BLK_W + PAGE_W + OFS_W
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic [PAGE_W-1:0] pg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [PHYS_W-1:0] phys
);

  assign phys = {blk, pg, ofs};

endmodule

// File: rtl/bankwin_regs.sv
module bankwin_regs
  import bankwin_pkg::*;
#(
  parameter bit WIDE_BLOCK = 1'b0,
  localparam int BLK_W  = WIDE_BLOCK ? 8 : 6,
  localparam int PHYS_W = BLK_W + PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  input  logic              io1_sel,
  input  logic              io2_sel,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_sel,
  output logic              mem_we
);

  logic              blk_wr, pg_wr;
  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] pg_q;
  logic [BLK_W-1:0]  blk_d;
  logic [PAGE_W-1:0] pg_d;

  bankwin_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .io1_sel  (io1_sel),
    .io2_sel  (io2_sel),
    .win_hit  (mem_sel),
    .win_we   (mem_we),
    .blk_wr   (blk_wr),
    .pg_wr    (pg_wr)
  );

  // R8/R9: the block width picks how many data bits are kept
  generate
    if (BLK_W < 8) begin : g_narrow
      logic [7-BLK_W:0] unused_blk_bits;
      assign blk_d = cpu_data[BLK_W-1:0];
      assign unused_blk_bits = cpu_data[7:BLK_W];
    end else begin : g_full
      assign blk_d = cpu_data[BLK_W-1:0];
    end
  endgenerate

  // R3: the page register keeps 6 bits
  logic [7-PAGE_W:0] unused_pg_bits;
  assign pg_d = cpu_data[PAGE_W-1:0];
  assign unused_pg_bits = cpu_data[7:PAGE_W];

  bankwin_reg #(.W(BLK_W)) u_blk (
    .clk (clk), .rst_n (rst_n), .load (blk_wr), .d (blk_d), .q (blk_q)
  );

  bankwin_reg #(.W(PAGE_W)) u_pg (
    .clk (clk), .rst_n (rst_n), .load (pg_wr), .d (pg_d), .q (pg_q)
  );

  bankwin_compose #(.BLK_W(BLK_W)) u_compose (
    .blk  (blk_q),
    .pg   (pg_q),
    .ofs  (cpu_addr[OFS_W-1:0]),
    .phys (mem_addr)
  );

  // R5: window strobe only with I/O-1 active
  p_sel_io1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |-> io1_sel);
  // R6: direction follows the CPU cycle type
  p_we_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cpu_wr && mem_sel));
  // R4: low byte passes straight through, upper bits follow the registers
  p_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);
  p_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[OFS_W+PAGE_W-1:OFS_W] == pg_q);

endmodule

// File: tb/bankwin_regs_tb.sv
module bankwin_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic        io1_sel = 1'b0;
  logic        io2_sel = 1'b0;
  logic [19:0] mem_addr;
  logic        mem_sel, mem_we;
  logic [21:0] w_addr;
  logic        w_sel, w_we;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bankwin_regs u_dut (
    .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
    .cpu_wr (cpu_wr), .io1_sel (io1_sel), .io2_sel (io2_sel),
    .mem_addr (mem_addr), .mem_sel (mem_sel), .mem_we (mem_we)
  );

  bankwin_regs #(.WIDE_BLOCK(1'b1)) u_dut_wide (
    .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
    .cpu_wr (cpu_wr), .io1_sel (io1_sel), .io2_sel (io2_sel),
    .mem_addr (w_addr), .mem_sel (w_sel), .mem_we (w_we)
  );

  typedef struct packed {
    logic        wr;
    logic        io1;
    logic        io2;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        e_sel;
    logic        e_we;
    logic [5:0]  e_blk;   // register contents expected during this vector
    logic [5:0]  e_pg;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,16'hDE12,8'h00, 1'b1,1'b0,6'h00,6'h00}, // R1 R5 read window
    '{1'b1,1'b0,1'b1,16'hDFFF,8'h2A, 1'b0,1'b0,6'h00,6'h00}, // R2 write block
    '{1'b1,1'b0,1'b1,16'hDFFE,8'h15, 1'b0,1'b0,6'h2A,6'h00}, // R3 write page
    '{1'b0,1'b1,1'b0,16'hDE80,8'h00, 1'b1,1'b0,6'h2A,6'h15}, // R4 composed
    '{1'b1,1'b1,1'b0,16'hDEFF,8'h77, 1'b1,1'b1,6'h2A,6'h15}, // R6 window write
    '{1'b1,1'b0,1'b1,16'hDFFF,8'hFF, 1'b0,1'b0,6'h2A,6'h15}, // R8 top bits
    '{1'b1,1'b0,1'b1,16'hDFFE,8'hC7, 1'b0,1'b0,6'h3F,6'h15}, // R3 page top bits
    '{1'b0,1'b1,1'b0,16'hDE00,8'h00, 1'b1,1'b0,6'h3F,6'h07}, // R8 R3 result
    '{1'b1,1'b0,1'b0,16'hDFFF,8'h01, 1'b0,1'b0,6'h3F,6'h07}, // R7 no io2
    '{1'b0,1'b0,1'b1,16'hDFFF,8'h01, 1'b0,1'b0,6'h3F,6'h07}, // R7 read reg
    '{1'b1,1'b0,1'b1,16'hDFFD,8'h05, 1'b0,1'b0,6'h3F,6'h07}, // R7 wrong addr
    '{1'b0,1'b1,1'b0,16'hDF00,8'h00, 1'b0,1'b0,6'h3F,6'h07}, // R5 io1 off page
    '{1'b0,1'b0,1'b0,16'hDE20,8'h00, 1'b0,1'b0,6'h3F,6'h07}, // R5 no io1
    '{1'b0,1'b1,1'b0,16'hDE01,8'h00, 1'b1,1'b0,6'h3F,6'h07}, // R7 unchanged
    '{1'b1,1'b0,1'b1,16'hDFFF,8'h00, 1'b0,1'b0,6'h3F,6'h07}, // R2 block to 0
    '{1'b0,1'b1,1'b0,16'hDEAB,8'h00, 1'b1,1'b0,6'h00,6'h07}  // R4 result
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic io1, input logic io2,
                       input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = wr; io1_sel = io1; io2_sel = io2; cpu_addr = a; cpu_data = d;
    #2;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    drive(1'b0, 1'b1, 1'b0, 16'hDE5A, 8'h00);
    check("R1 reset addr", 32'(mem_addr), 32'h0005A);
    check("R1 reset wide addr", 32'(w_addr), 32'h0005A);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].wr, TBL[i].io1, TBL[i].io2, TBL[i].addr, TBL[i].data);
      check($sformatf("R4 vec%0d mem_addr", i), 32'(mem_addr),
            32'({TBL[i].e_blk, TBL[i].e_pg, TBL[i].addr[7:0]}));
      check($sformatf("R5 vec%0d mem_sel", i), 32'(mem_sel), 32'(TBL[i].e_sel));
      check($sformatf("R6 vec%0d mem_we", i), 32'(mem_we), 32'(TBL[i].e_we));
    end

    // R1: reset in mid-run clears both registers
    drive(1'b1, 1'b0, 1'b1, 16'hDFFF, 8'h11);
    drive(1'b1, 1'b0, 1'b1, 16'hDFFE, 8'h22);
    drive(1'b0, 1'b1, 1'b0, 16'hDE33, 8'h00);
    check("R2 R3 before reset", 32'(mem_addr), 32'({6'h11, 6'h22, 8'h33}));
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #2;
    check("R1 after mid reset", 32'(mem_addr), 32'h00033);

    // R9: wide block instance keeps all 8 bits
    drive(1'b1, 1'b0, 1'b1, 16'hDFFF, 8'hFF);
    drive(1'b1, 1'b0, 1'b1, 16'hDFFE, 8'hBF);
    drive(1'b1, 1'b1, 1'b0, 16'hDEC4, 8'h99);
    check("R9 wide addr", 32'(w_addr), 32'({8'hFF, 6'h3F, 8'hC4}));
    check("R8 narrow addr", 32'(mem_addr), 32'({6'h3F, 6'h3F, 8'hC4}));
    check("R9 wide we", 32'(w_we), 32'h1);
    drive(1'b1, 1'b0, 1'b1, 16'hDFFF, 8'h81);
    drive(1'b0, 1'b1, 1'b0, 16'hDE00, 8'h00);
    check("R9 wide bit7", 32'(w_addr), 32'({8'h81, 6'h3F, 8'h00}));
    check("R8 narrow bit7 dropped", 32'(mem_addr), 32'({6'h01, 6'h3F, 8'h00}));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule